// File: doc/BRIEF.md
# Prioritized Restart Interrupt Unit

This block sits beside a small processor core and decides, once per instruction, whether an interrupt is taken and where execution continues. It watches five request lines: a non-maskable line, three maskable restart lines (high, middle and low rank) and one general request line. It resolves their priority, applies a global enable and per-line masks, and produces either a fixed vector address or an acknowledge cycle that fetches a restart opcode from the requesting device.

The core pulses `boundary` in the last cycle of each instruction, and requests are only evaluated in that cycle. A fixed-vector source is taken one cycle later: `take_irq` pulses and `vec_addr` holds the target. While `take_irq` is high the core must not advance its program counter. A general request first raises `ack_cycle` for one cycle. During that cycle the device drives a restart opcode onto `ack_opcode`, and the vector follows one cycle later. Every accepted interrupt clears the global enable. Software turns it back on with `en_set`.

The high-rank restart line is edge-captured, so a short pulse is remembered until it is serviced or explicitly cleared. The non-maskable line must rise and then stay high before it counts, which rejects single-cycle glitches.

Top module: `restart_irq_unit`

## Requirements
- R1: After reset `take_irq`, `ack_cycle` and `irq_enabled` are 0, `vec_addr` is 0, and all three restart masks are set, so a restart request alone is not taken even once the enable is on.
- R2: On a boundary, at most one source is taken, chosen in this order from highest to lowest: non-maskable, high, middle, low, general.
- R3: A fixed source sets `vec_addr` one cycle after the boundary: 24h non-maskable, 3Ch high, 34h middle, 2Ch low. The vector holds until the next take.
- R4: The non-maskable line ignores the enable and the masks. It is taken only if it rose and was then still high on at least one later sampled edge. A line held high is taken once per rising edge.
- R5: A command with `msk_wr`=1 and `msk_apply`=1 loads the masks from `msk_bits` (bit 0 low, bit 1 middle, bit 2 high; 1 = masked). With `msk_apply`=0 the masks stay unchanged.
- R6: A rising edge on `req_hi_in` sets a latch, even while that line is masked. The latch stays set after the line falls. It is cleared when the high source is taken, or by a command with `msk_wr`=1 and `hi_latch_clr`=1.
- R7: `en_set` sets the enable and `en_clr` clears it; `en_clr` wins over `en_set`. Accepting any interrupt clears the enable, and this wins over `en_set` in the same cycle.
- R8: A taken general request raises `ack_cycle` for exactly one cycle after the boundary. The opcode is sampled during that cycle. An opcode of the form 11nnn111 yields `take_irq` in the next cycle with vector n*8. Any other opcode yields no take and leaves the vector unchanged.
- R9: Requests are evaluated only in a cycle with `boundary`=1. A boundary during the `ack_cycle` cycle is ignored. Every `take_irq` pulse follows either a boundary or an `ack_cycle` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Non-maskable request line |
| req_hi_in | input | 1 | High-rank restart request (edge-captured) |
| req_mid_in | input | 1 | Middle-rank restart request (level) |
| req_lo_in | input | 1 | Low-rank restart request (level) |
| gen_req_in | input | 1 | General request, serviced through an acknowledge cycle |
| en_set | input | 1 | Enable-interrupts command |
| en_clr | input | 1 | Disable-interrupts command |
| msk_wr | input | 1 | Mask command strobe |
| msk_bits | input | 3 | Mask values: bit 0 low, bit 1 middle, bit 2 high |
| msk_apply | input | 1 | Load `msk_bits` during a mask command |
| hi_latch_clr | input | 1 | Clear the high-rank latch during a mask command |
| boundary | input | 1 | Instruction-boundary strobe |
| ack_opcode | input | 8 | Opcode returned by the device during the acknowledge cycle |
| take_irq | output | 1 | One-cycle take pulse; program counter increment must be held off |
| vec_addr | output | ADDR_W | Vector address of the last take |
| ack_cycle | output | 1 | Acknowledge cycle for the general request |
| irq_enabled | output | 1 | Global enable state |

## Verification
The hardest state to reach from the ports is a boundary that arrives while an acknowledge cycle is in progress and a higher-priority source is already valid. The bench raises the non-maskable line in the same cycle as the boundary that takes a general request. The line is therefore armed, but not yet valid, when that boundary is sampled. It becomes valid exactly during the acknowledge cycle, where a second boundary is held. The bench then checks that the restart vector, not the non-maskable vector, comes out, and that the non-maskable request is taken at the next boundary.

// File: rtl/rirq_pkg.sv
package rirq_pkg;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_NMI,
    SRC_HI,
    SRC_MID,
    SRC_LO,
    SRC_GEN
  } irq_src_e;

  localparam int OPC_W = 8;

  // Fixed vectors are (rank * 8) + 4 with ranks 4..7.
  function automatic logic [7:0] fixed_vector(irq_src_e s);
    logic [2:0] rank;
    case (s)
      SRC_NMI: rank = 3'd4;
      SRC_LO:  rank = 3'd5;
      SRC_MID: rank = 3'd6;
      SRC_HI:  rank = 3'd7;
      default: rank = 3'd0;
    endcase
    return {2'b00, rank, 3'b100};
  endfunction

  function automatic logic is_restart(logic [OPC_W-1:0] op);
    return (op[7:6] == 2'b11) && (op[2:0] == 3'b111);
  endfunction

  function automatic logic [7:0] restart_vector(logic [OPC_W-1:0] op);
    return {2'b00, op[5:3], 3'b000};
  endfunction

endpackage

// File: rtl/rirq_nmi_qual.sv
module rirq_nmi_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic nmi_taken,
  output logic nmi_req
);
  logic nmi_prev, nmi_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev  <= 1'b0;
      nmi_armed <= 1'b0;
    end else begin
      nmi_prev <= nmi_in;
      if (!nmi_in || nmi_taken) nmi_armed <= 1'b0;
      else if (!nmi_prev)       nmi_armed <= 1'b1;
    end
  end

  assign nmi_req = nmi_armed & nmi_in;

  // R4: a valid request implies the line was already high one edge earlier
  a_r4_nmi_sustained: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> $past(nmi_in));

endmodule

// File: rtl/rirq_src_gate.sv
module rirq_src_gate #(
  parameter int N_LVL = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_hi_in,
  input  logic [N_LVL-1:0] lvl_in,   // [1] middle, [0] low
  input  logic       gen_req_in,
  input  logic       msk_wr,
  input  logic [2:0] msk_bits,
  input  logic       msk_apply,
  input  logic       hi_latch_clr,
  input  logic       hi_taken,
  input  logic       enabled,
  output logic       hi_req,
  output logic [N_LVL-1:0] lvl_req,
  output logic       gen_req
);
  localparam int N_MSK = N_LVL + 1;

  logic [N_MSK-1:0] mask_q;
  logic hi_prev, hi_lat;
  logic mask_load, lat_clear, hi_rise;

  assign mask_load = msk_wr & msk_apply;
  assign lat_clear = hi_taken | (msk_wr & hi_latch_clr);
  assign hi_rise   = req_hi_in & ~hi_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      hi_prev <= 1'b0;
      hi_lat  <= 1'b0;
    end else begin
      if (mask_load) mask_q <= msk_bits[N_MSK-1:0];
      hi_prev <= req_hi_in;
      if (hi_rise)        hi_lat <= 1'b1;
      else if (lat_clear) hi_lat <= 1'b0;
    end
  end

  for (genvar i = 0; i < N_LVL; i++) begin : g_lvl
    assign lvl_req[i] = lvl_in[i] & ~mask_q[i] & enabled;
  end

  assign hi_req  = hi_lat & ~mask_q[N_MSK-1] & enabled;
  assign gen_req = gen_req_in & enabled;

  // R5: masks change only on an apply command
  a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_load |=> $stable(mask_q));
  // R6: latch survives until taken or cleared
  a_r6_latch_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_lat && !hi_taken && !(msk_wr && hi_latch_clr)) |=> hi_lat);
  // R7: nothing maskable passes while disabled
  a_r7_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> !(hi_req || gen_req || (lvl_req != '0)));

endmodule

// File: rtl/rirq_arbiter.sv
module rirq_arbiter
  import rirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic             nmi_req,
  input  logic             hi_req,
  input  logic             mid_req,
  input  logic             lo_req,
  input  logic             gen_req,
  input  logic             en_set,
  input  logic             en_clr,
  input  logic [OPC_W-1:0] ack_opcode,
  output logic             take_irq,
  output logic [7:0]       vec8,
  output logic             ack_cycle,
  output logic             enabled,
  output logic             nmi_taken,
  output logic             hi_taken
);
  typedef enum logic {ST_IDLE, ST_ACK} st_e;

  st_e      state;
  irq_src_e winner;
  logic     accept;

  always_comb begin
    if      (nmi_req) winner = SRC_NMI;
    else if (hi_req)  winner = SRC_HI;
    else if (mid_req) winner = SRC_MID;
    else if (lo_req)  winner = SRC_LO;
    else if (gen_req) winner = SRC_GEN;
    else              winner = SRC_NONE;
  end

  assign accept    = boundary && (state == ST_IDLE) && (winner != SRC_NONE);
  assign nmi_taken = accept && (winner == SRC_NMI);
  assign hi_taken  = accept && (winner == SRC_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      take_irq  <= 1'b0;
      ack_cycle <= 1'b0;
      vec8      <= '0;
      enabled   <= 1'b0;
    end else begin
      take_irq  <= 1'b0;
      ack_cycle <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          if (winner == SRC_GEN) begin
            ack_cycle <= 1'b1;
            state     <= ST_ACK;
          end else begin
            take_irq <= 1'b1;
            vec8     <= fixed_vector(winner);
          end
        end
        ST_ACK: begin
          state <= ST_IDLE;
          if (is_restart(ack_opcode)) begin
            take_irq <= 1'b1;
            vec8     <= restart_vector(ack_opcode);
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (accept)      enabled <= 1'b0;
      else if (en_clr) enabled <= 1'b0;
      else if (en_set) enabled <= 1'b1;
    end
  end

  // R8: acknowledge lasts a single cycle
  a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack_cycle |=> !ack_cycle);
  // R8: opcode-derived vectors are multiples of eight
  a_r8_restart_align: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && $past(ack_cycle)) |-> (vec8[2:0] == 3'b000));
  // R3: fixed vectors end in 100b and lie in 24h..3Ch
  a_r3_fixed_form: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && !$past(ack_cycle)) |-> (vec8[2:0] == 3'b100 && vec8[5] && !vec8[7]));
  // R9: every take has a cause
  a_r9_take_cause: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> ($past(boundary) || $past(ack_cycle)));
  // R7: acceptance leaves the enable off
  a_r7_accept_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_cycle || (take_irq && !$past(ack_cycle))) |-> !enabled);

endmodule

// File: rtl/restart_irq_unit.sv
module restart_irq_unit #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_in,
  input  logic              req_hi_in,
  input  logic              req_mid_in,
  input  logic              req_lo_in,
  input  logic              gen_req_in,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              msk_wr,
  input  logic [2:0]        msk_bits,
  input  logic              msk_apply,
  input  logic              hi_latch_clr,
  input  logic              boundary,
  input  logic [7:0]        ack_opcode,
  output logic              take_irq,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              ack_cycle,
  output logic              irq_enabled
);
  localparam int PAD_W = ADDR_W - 8;

  logic       nmi_req, nmi_taken, hi_taken;
  logic       hi_req, gen_req;
  logic [1:0] lvl_req;
  logic [7:0] vec8;

  rirq_nmi_qual u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in),
    .nmi_taken(nmi_taken), .nmi_req(nmi_req)
  );

  rirq_src_gate #(.N_LVL(2)) u_gate (
    .clk(clk), .rst_n(rst_n), .req_hi_in(req_hi_in),
    .lvl_in({req_mid_in, req_lo_in}), .gen_req_in(gen_req_in),
    .msk_wr(msk_wr), .msk_bits(msk_bits), .msk_apply(msk_apply),
    .hi_latch_clr(hi_latch_clr), .hi_taken(hi_taken), .enabled(irq_enabled),
    .hi_req(hi_req), .lvl_req(lvl_req), .gen_req(gen_req)
  );

  rirq_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .boundary(boundary),
    .nmi_req(nmi_req), .hi_req(hi_req), .mid_req(lvl_req[1]),
    .lo_req(lvl_req[0]), .gen_req(gen_req),
    .en_set(en_set), .en_clr(en_clr), .ack_opcode(ack_opcode),
    .take_irq(take_irq), .vec8(vec8), .ack_cycle(ack_cycle),
    .enabled(irq_enabled), .nmi_taken(nmi_taken), .hi_taken(hi_taken)
  );

  assign vec_addr = {{PAD_W{1'b0}}, vec8};

  // R4: the non-maskable vector is only produced after the line was high
  a_r4_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && vec_addr == ADDR_W'(8'h24)) |-> $past(nmi_in, 2));
  // R2: take and acknowledge never coincide
  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_irq, ack_cycle}));

endmodule

// File: tb/restart_irq_unit_bench.sv
module restart_irq_unit_bench;
  localparam int ADDR_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_in = 0, req_hi_in = 0, req_mid_in = 0, req_lo_in = 0, gen_req_in = 0;
  logic en_set = 0, en_clr = 0, msk_wr = 0, msk_apply = 0, hi_latch_clr = 0;
  logic [2:0] msk_bits = 3'b000;
  logic boundary = 0;
  logic [7:0] ack_opcode = 8'h00;
  logic take_irq, ack_cycle, irq_enabled;
  logic [ADDR_W-1:0] vec_addr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  restart_irq_unit #(.ADDR_W(ADDR_W)) u_restart_irq_unit (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .req_hi_in(req_hi_in),
    .req_mid_in(req_mid_in), .req_lo_in(req_lo_in), .gen_req_in(gen_req_in),
    .en_set(en_set), .en_clr(en_clr), .msk_wr(msk_wr), .msk_bits(msk_bits),
    .msk_apply(msk_apply), .hi_latch_clr(hi_latch_clr), .boundary(boundary),
    .ack_opcode(ack_opcode), .take_irq(take_irq), .vec_addr(vec_addr),
    .ack_cycle(ack_cycle), .irq_enabled(irq_enabled)
  );

  // ---------------- behavioural reference model ----------------
  bit m_en, m_take, m_ack, m_pend_ack, m_lat, m_hi_prev, m_nmi_prev, m_nmi_ok;
  bit [2:0] m_mask;
  int m_vec;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_take = 0; m_ack = 0; m_pend_ack = 0; m_lat = 0;
      m_hi_prev = 0; m_nmi_prev = 0; m_nmi_ok = 0; m_mask = 3'b111; m_vec = 0;
    end else begin
      int pick;
      pick = -1;
      m_take = 0;
      m_ack = 0;
      if (boundary && !m_pend_ack) begin
        if (m_nmi_ok && nmi_in)                     pick = 0;
        else if (m_en && m_lat && !m_mask[2])       pick = 1;
        else if (m_en && req_mid_in && !m_mask[1])  pick = 2;
        else if (m_en && req_lo_in && !m_mask[0])   pick = 3;
        else if (m_en && gen_req_in)                pick = 4;
      end
      if (m_pend_ack) begin
        m_pend_ack = 0;
        if ((ack_opcode & 8'hC7) == 8'hC7) begin
          m_take = 1;
          m_vec = int'(ack_opcode & 8'h38);
        end
      end else if (pick == 4) begin
        m_ack = 1;
        m_pend_ack = 1;
      end else if (pick >= 0) begin
        m_take = 1;
        case (pick)
          0: m_vec = 36;
          1: m_vec = 60;
          2: m_vec = 52;
          default: m_vec = 44;
        endcase
      end
      if (pick >= 0) m_en = 0;
      else if (en_clr) m_en = 0;
      else if (en_set) m_en = 1;
      if (req_hi_in && !m_hi_prev) m_lat = 1;
      else if (pick == 1 || (msk_wr && hi_latch_clr)) m_lat = 0;
      m_hi_prev = req_hi_in;
      if (!nmi_in || pick == 0) m_nmi_ok = 0;
      else if (!m_nmi_prev) m_nmi_ok = 1;
      m_nmi_prev = nmi_in;
      if (msk_wr && msk_apply) m_mask = msk_bits;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      chk("R2 model take_irq", int'(take_irq), int'(m_take));
      chk("R3 model vec_addr", int'(vec_addr), m_vec);
      chk("R8 model ack_cycle", int'(ack_cycle), int'(m_ack));
      chk("R7 model irq_enabled", int'(irq_enabled), int'(m_en));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(negedge clk);
  endtask

  task automatic strobe();
    boundary = 1; step(); boundary = 0;
  endtask

  task automatic enable();
    en_set = 1; step(); en_set = 0;
  endtask

  task automatic mask_cmd(input logic [2:0] bits, input logic apply, input logic clr);
    msk_wr = 1; msk_bits = bits; msk_apply = apply; hi_latch_clr = clr;
    step();
    msk_wr = 0; msk_apply = 0; hi_latch_clr = 0;
  endtask

  task automatic pulse_hi();
    req_hi_in = 1; step(); req_hi_in = 0; step();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk("R1 reset take_irq", int'(take_irq), 0);
    chk("R1 reset ack_cycle", int'(ack_cycle), 0);
    chk("R1 reset irq_enabled", int'(irq_enabled), 0);
    chk("R1 reset vec_addr", int'(vec_addr), 0);
    rst_n = 1; step();

    enable();
    chk("R7 en_set", int'(irq_enabled), 1);
    req_lo_in = 1; strobe();
    chk("R1 masks set after reset", int'(take_irq), 0);

    mask_cmd(3'b000, 1, 0);
    strobe();
    chk("R5 unmask low take", int'(take_irq), 1);
    chk("R3 low vector 2Ch", int'(vec_addr), 'h2C);
    chk("R7 cleared on accept", int'(irq_enabled), 0);
    step();
    chk("R9 take lasts one cycle", int'(take_irq), 0);

    enable(); req_mid_in = 1; gen_req_in = 1; strobe();
    chk("R2 middle over low", int'(vec_addr), 'h34);
    enable(); req_mid_in = 0; strobe();
    chk("R2 low over general", int'(vec_addr), 'h2C);
    chk("R2 no ack when low wins", int'(ack_cycle), 0);

    enable(); mask_cmd(3'b001, 1, 0); strobe();
    chk("R5 masked low skipped", int'(ack_cycle), 1);
    chk("R8 no take during ack", int'(take_irq), 0);
    ack_opcode = 8'hEF; step(); ack_opcode = 8'h00;
    chk("R8 restart take", int'(take_irq), 1);
    chk("R8 restart vector 28h", int'(vec_addr), 'h28);

    mask_cmd(3'b000, 0, 0); enable(); strobe();
    chk("R5 no-apply keeps mask", int'(ack_cycle), 1);
    ack_opcode = 8'hCD; step(); ack_opcode = 8'h00;
    chk("R8 non-restart no take", int'(take_irq), 0);
    chk("R8 vector unchanged", int'(vec_addr), 'h28);

    req_lo_in = 0; gen_req_in = 0;
    mask_cmd(3'b000, 1, 0);
    pulse_hi(); step();
    enable(); strobe();
    chk("R6 latched high taken", int'(vec_addr), 'h3C);
    chk("R6 latched high take", int'(take_irq), 1);
    enable(); strobe();
    chk("R6 latch cleared by take", int'(take_irq), 0);
    pulse_hi(); mask_cmd(3'b000, 0, 1); strobe();
    chk("R6 latch cleared by command", int'(take_irq), 0);
    mask_cmd(3'b100, 1, 0); pulse_hi(); strobe();
    chk("R6 masked latch not taken", int'(take_irq), 0);
    mask_cmd(3'b000, 1, 0); strobe();
    chk("R6 latch kept while masked", int'(vec_addr), 'h3C);

    mask_cmd(3'b111, 1, 0);
    nmi_in = 1; step(); nmi_in = 0; step(); strobe();
    chk("R4 short pulse rejected", int'(take_irq), 0);
    nmi_in = 1; step(); step(); strobe();
    chk("R4 sustained taken while disabled", int'(vec_addr), 'h24);
    chk("R4 sustained take", int'(take_irq), 1);
    strobe();
    chk("R4 no retake without new edge", int'(take_irq), 0);
    nmi_in = 0; step();

    mask_cmd(3'b000, 1, 0); pulse_hi(); enable();
    nmi_in = 1; step(); step(); strobe();
    chk("R2 non-maskable over high", int'(vec_addr), 'h24);
    chk("R7 cleared by non-maskable", int'(irq_enabled), 0);
    nmi_in = 0; enable(); strobe();
    chk("R2 high still pending", int'(vec_addr), 'h3C);

    enable(); gen_req_in = 1; nmi_in = 1; boundary = 1; step();
    chk("R9 general taken first", int'(ack_cycle), 1);
    ack_opcode = 8'hFF; step();
    boundary = 0; ack_opcode = 8'h00; gen_req_in = 0;
    chk("R9 boundary in ack ignored", int'(vec_addr), 'h38);
    strobe();
    chk("R9 non-maskable after ack", int'(vec_addr), 'h24);
    nmi_in = 0; step();

    en_set = 1; en_clr = 1; step(); en_set = 0; en_clr = 0;
    chk("R7 clear wins over set", int'(irq_enabled), 0);
    enable();
    req_lo_in = 1; boundary = 1; en_set = 1; step();
    boundary = 0; en_set = 0;
    chk("R7 accept wins over set", int'(irq_enabled), 0);
    chk("R7 accept take", int'(take_irq), 1);

    enable();
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R9 no take without boundary", int'(take_irq), 0);
    end
    req_lo_in = 0; step(); step();

    done = 1;
    summary();
    $finish;
  end

endmodule